// File: doc/BRIEF.md
# DMA Request Router

This block sits between a set of peripheral DMA request lines and a bank of DMA channels. A table holds one small entry per request line. Each entry says whether the line is routed at all and, if so, to which channel. Software fills the table through a simple register port. The table is reached at byte offsets in two separate windows: a low window for the first lines and a high window for the rest.

Each request input is registered once. From the registered value and its previous value, the block derives a level and two edge events per line. It then folds them onto channels through the table. For every channel it drives four outputs:

- the combined request level;
- a one-cycle pulse that sets the channel's request-after-stop status on a rising edge;
- a one-cycle pulse that clears that status on a falling edge;
- a one-cycle pulse that sets the channel's end-of-receive status on a falling edge.

The status register itself lives in the channel logic, as do arbitration and data movement.

A write that marks an entry valid but names a channel the block does not have is refused. Such a write leaves the entry unchanged and raises a sticky error flag.

Top module: `dmr_req_router`

## Requirements
- R1: After reset every entry reads zero (not routed), all channel levels and pulses are low, and the error flag is low.
- R2: An entry holds a valid bit at bit 7 and a channel number in bits 4:0. Reads return those fields in those positions, and bits 6:5 always read as zero.
- R3: Entry i (0 to 63) sits at byte offset 0x100 + 4*i, and entry i (64 to 74) at 0x1100 + 4*(i-64). Any other offset, including a misaligned one, reads zero, and a write to it changes no entry.
- R4: A channel's level is the OR of every request line whose entry is valid and names that channel. It follows a change on the input one clock edge later.
- R5: A request line whose entry has the valid bit clear has no effect on any channel output.
- R6: One clock edge after a routed line goes from low to high, its channel's request-after-stop set pulse is high for exactly one cycle.
- R7: One clock edge after a routed line goes from high to low, its channel's end-of-receive set pulse and its request-after-stop clear pulse are high for one cycle.
- R8: Events from several lines routed to one channel combine by OR. When a set and a clear of request-after-stop fall on the same channel in the same cycle, the set wins and the clear stays low.
- R9: A write with the valid bit set and a channel number at or above the channel count leaves the entry unchanged. It raises the error flag, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 16 | Byte offset for table read and write |
| cfg_wdata | input | 8 | Entry write data |
| cfg_rdata | output | 8 | Entry read data (combinational from cfg_addr) |
| cfg_err | output | 1 | Sticky flag for a refused channel number |
| req_i | input | 75 | Peripheral request lines |
| ch_level_o | output | 16 | Combined request level per channel |
| ras_set_o | output | 16 | Request-after-stop set pulse per channel |
| ras_clr_o | output | 16 | Request-after-stop clear pulse per channel |
| eor_set_o | output | 16 | End-of-receive set pulse per channel |

## Verification
The bench builds the router with its default sizes: 75 request lines and 16 channels.

Since 75 exceeds 64, both address windows hold live entries, including the last slot at 0x1128. Since the 5-bit channel field can name channels 16 to 31, which do not exist, random writes regularly hit the refused-write path.

With 75 lines folded onto 16 channels, several lines often share a channel. As a result, same-cycle rising and falling edges on one channel occur under random toggling, alongside the directed cases.

// File: rtl/dmr_pkg.sv
package dmr_pkg;

    localparam int CH_FIELD_W = 5;

    typedef struct packed {
        logic                  vld;
        logic [CH_FIELD_W-1:0] ch;
    } map_ent_t;

endpackage

// File: rtl/dmr_addr_dec.sv
module dmr_addr_dec #(
    parameter int          NUM_REQ  = 75,
    parameter int          LO_COUNT = 64,
    parameter int unsigned LO_BASE  = 32'h100,
    parameter int unsigned HI_BASE  = 32'h1100,
    parameter int          AW       = 16,
    localparam int         IDX_W    = $clog2(NUM_REQ)
) (
    input  logic [AW-1:0]    addr,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    localparam int unsigned LO_END = LO_BASE + 32'(4 * LO_COUNT);
    localparam int unsigned HI_END = HI_BASE + 32'(4 * (NUM_REQ - LO_COUNT));

    logic [31:0] a;
    logic [31:0] off;

    always_comb begin
        a   = 32'(addr);
        hit = 1'b0;
        idx = '0;
        off = '0;
        if (a[1:0] == 2'b00) begin
            if (a >= LO_BASE && a < LO_END) begin
                hit = 1'b1;
                off = (a - LO_BASE) >> 2;
                idx = IDX_W'(off);
            end else if (a >= HI_BASE && a < HI_END) begin
                hit = 1'b1;
                off = ((a - HI_BASE) >> 2) + 32'(LO_COUNT);
                idx = IDX_W'(off);
            end
        end
    end
endmodule

// File: rtl/dmr_edge.sv
module dmr_edge #(
    parameter int N = 75
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    typedef struct packed {
        logic [N-1:0] cur;
        logic [N-1:0] old;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.old = st_q.cur;
        st_d.cur = req_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o  = st_q.cur;
    assign rise_o = st_q.cur & ~st_q.old;
    assign fall_o = ~st_q.cur & st_q.old;
endmodule

// File: rtl/dmr_ch_fold.sv
module dmr_ch_fold
    import dmr_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 16
) (
    input  map_ent_t [NUM_REQ-1:0] map,
    input  logic     [NUM_REQ-1:0] lvl,
    input  logic     [NUM_REQ-1:0] rise,
    input  logic     [NUM_REQ-1:0] fall,
    output logic     [NUM_CH-1:0]  ch_level,
    output logic     [NUM_CH-1:0]  ras_set,
    output logic     [NUM_CH-1:0]  ras_clr,
    output logic     [NUM_CH-1:0]  eor_set
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic any_lvl, any_rise, any_fall;
        always_comb begin
            any_lvl  = 1'b0;
            any_rise = 1'b0;
            any_fall = 1'b0;
            for (int i = 0; i < NUM_REQ; i++) begin
                if (map[i].vld && map[i].ch == CH_FIELD_W'(c)) begin
                    any_lvl  = any_lvl  | lvl[i];
                    any_rise = any_rise | rise[i];
                    any_fall = any_fall | fall[i];
                end
            end
        end
        assign ch_level[c] = any_lvl;
        assign ras_set[c]  = any_rise;
        assign ras_clr[c]  = any_fall & ~any_rise;
        assign eor_set[c]  = any_fall;
    end
endmodule

// File: rtl/dmr_req_router.sv
module dmr_req_router
    import dmr_pkg::*;
#(
    parameter int          NUM_REQ  = 75,
    parameter int          NUM_CH   = 16,
    parameter int          LO_COUNT = 64,
    parameter int unsigned LO_BASE  = 32'h100,
    parameter int unsigned HI_BASE  = 32'h1100,
    parameter int          AW       = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [AW-1:0]      cfg_addr,
    input  logic [7:0]         cfg_wdata,
    output logic [7:0]         cfg_rdata,
    output logic               cfg_err,
    input  logic [NUM_REQ-1:0] req_i,
    output logic [NUM_CH-1:0]  ch_level_o,
    output logic [NUM_CH-1:0]  ras_set_o,
    output logic [NUM_CH-1:0]  ras_clr_o,
    output logic [NUM_CH-1:0]  eor_set_o
);
    localparam int IDX_W = $clog2(NUM_REQ);

    typedef struct packed {
        map_ent_t [NUM_REQ-1:0] map;
        logic                   err;
    } rt_st_t;

    rt_st_t st_d, st_q;

    logic             hit;
    logic [IDX_W-1:0] idx;
    logic             bad_ch;
    map_ent_t         rd_ent;

    logic [NUM_REQ-1:0] lvl, rise, fall;

    dmr_addr_dec #(
        .NUM_REQ (NUM_REQ),
        .LO_COUNT(LO_COUNT),
        .LO_BASE (LO_BASE),
        .HI_BASE (HI_BASE),
        .AW      (AW)
    ) i_dec (
        .addr(cfg_addr),
        .hit (hit),
        .idx (idx)
    );

    dmr_edge #(.N(NUM_REQ)) i_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (req_i),
        .lvl_o (lvl),
        .rise_o(rise),
        .fall_o(fall)
    );

    always_comb begin
        st_d   = st_q;
        bad_ch = cfg_wdata[7] &&
                 ({1'b0, cfg_wdata[CH_FIELD_W-1:0]} >= (CH_FIELD_W+1)'(NUM_CH));
        if (cfg_we && hit) begin
            if (bad_ch) begin
                st_d.err = 1'b1;
            end else begin
                st_d.map[idx].vld = cfg_wdata[7];
                st_d.map[idx].ch  = cfg_wdata[CH_FIELD_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_ent    = st_q.map[idx];
    assign cfg_rdata = hit ? {rd_ent.vld, 2'b00, rd_ent.ch} : 8'h00;
    assign cfg_err   = st_q.err;

    dmr_ch_fold #(
        .NUM_REQ(NUM_REQ),
        .NUM_CH (NUM_CH)
    ) i_fold (
        .map     (st_q.map),
        .lvl     (lvl),
        .rise    (rise),
        .fall    (fall),
        .ch_level(ch_level_o),
        .ras_set (ras_set_o),
        .ras_clr (ras_clr_o),
        .eor_set (eor_set_o)
    );
endmodule

// File: rtl/dmr_req_router_chk.sv
module dmr_req_router_chk #(
    parameter int          NUM_REQ = 75,
    parameter int          NUM_CH  = 16,
    parameter int unsigned LO_BASE = 32'h100,
    parameter int          AW      = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_we,
    input logic [AW-1:0]      cfg_addr,
    input logic [7:0]         cfg_wdata,
    input logic [7:0]         cfg_rdata,
    input logic               cfg_err,
    input logic [NUM_CH-1:0]  ch_level_o,
    input logic [NUM_CH-1:0]  ras_set_o,
    input logic [NUM_CH-1:0]  ras_clr_o,
    input logic [NUM_CH-1:0]  eor_set_o
);
    logic lo_slot, refused;
    assign lo_slot = (32'(cfg_addr) >= LO_BASE) && (32'(cfg_addr) < LO_BASE + 32'd256)
                     && (cfg_addr[1:0] == 2'b00);
    assign refused = cfg_we && lo_slot && cfg_wdata[7] &&
                     (32'(cfg_wdata[4:0]) >= 32'(NUM_CH));

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[6:5] == 2'b00);

    a_r3_misaligned_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr[1:0] != 2'b00) |-> (cfg_rdata == 8'h00));

    a_r6_set_implies_level: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_set_o & ~ch_level_o) == '0);

    a_r7_clr_implies_eor: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_clr_o & ~eor_set_o) == '0);

    a_r8_set_beats_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_set_o & ras_clr_o) == '0);

    a_r9_refused_flags: assert property (@(posedge clk) disable iff (!rst_n)
        refused |=> cfg_err);

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);
endmodule

bind dmr_req_router dmr_req_router_chk #(
    .NUM_REQ(NUM_REQ),
    .NUM_CH (NUM_CH),
    .LO_BASE(LO_BASE),
    .AW     (AW)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .cfg_err   (cfg_err),
    .ch_level_o(ch_level_o),
    .ras_set_o (ras_set_o),
    .ras_clr_o (ras_clr_o),
    .eor_set_o (eor_set_o)
);

// File: tb/test_dmr_req_router.sv
`timescale 1ns/1ps
module test_dmr_req_router;
    localparam int CLK_PERIOD = 10;
    localparam int NREQ = 75;
    localparam int NCH  = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [15:0]     cfg_addr = '0;
    logic [7:0]      cfg_wdata = '0;
    logic [7:0]      cfg_rdata;
    logic            cfg_err;
    logic [NREQ-1:0] req_i = '0;
    logic [NCH-1:0]  ch_level_o, ras_set_o, ras_clr_o, eor_set_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmr_req_router i_dmr_req_router (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
        .req_i(req_i), .ch_level_o(ch_level_o), .ras_set_o(ras_set_o),
        .ras_clr_o(ras_clr_o), .eor_set_o(eor_set_o)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [5:0]      m_map [NREQ];
    logic            m_err;
    logic [NREQ-1:0] m_cur, m_old;

    function automatic logic [15:0] slot_addr(int i);
        if (i < 64) return 16'(32'h100 + 4 * i);
        return 16'(32'h1100 + 4 * (i - 64));
    endfunction

    function automatic int slot_of(logic [15:0] a);
        for (int i = 0; i < NREQ; i++)
            if (slot_addr(i) == a) return i;
        return -1;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_outputs(string tag);
        logic [NCH-1:0] lv, rs, fl;
        lv = '0; rs = '0; fl = '0;
        for (int i = 0; i < NREQ; i++) begin
            if (m_map[i][5]) begin
                lv[m_map[i][3:0]] |= m_cur[i];
                rs[m_map[i][3:0]] |= m_cur[i] & ~m_old[i];
                fl[m_map[i][3:0]] |= ~m_cur[i] & m_old[i];
            end
        end
        check({tag, " R4 level"},      32'(ch_level_o), 32'(lv));
        check({tag, " R6 ras set"},    32'(ras_set_o),  32'(rs));
        check({tag, " R7 eor set"},    32'(eor_set_o),  32'(fl));
        check({tag, " R8 ras clr"},    32'(ras_clr_o),  32'(fl & ~rs));
        check({tag, " R9 err flag"},   32'(cfg_err),    32'(m_err));
    endtask

    // one clock: inputs already driven at a falling edge
    task automatic cycle(string tag);
        int s;
        @(posedge clk);
        m_old = m_cur;
        m_cur = req_i;
        if (cfg_we) begin
            s = slot_of(cfg_addr);
            if (s >= 0) begin
                if (cfg_wdata[7] && cfg_wdata[4:0] >= 5'(NCH)) m_err = 1'b1;
                else m_map[s] = {cfg_wdata[7], cfg_wdata[4:0]};
            end
        end
        @(negedge clk);
        cfg_we = 1'b0;
        check_outputs(tag);
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d, string tag);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        cycle(tag);
    endtask

    task automatic readback(string tag);
        cycle({tag, " settle"});
        for (int i = 0; i < NREQ; i++) begin
            cfg_addr = slot_addr(i);
            #0.05;
            check({tag, " R2 R3 readback"}, 32'(cfg_rdata),
                  32'({m_map[i][5], 2'b00, m_map[i][4:0]}));
        end
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed1234));
        for (int i = 0; i < NREQ; i++) m_map[i] = '0;
        m_err = 0; m_cur = '0; m_old = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_outputs("R1 reset");
        readback("R1 reset");

        // R2 field layout, bits 6:5 dropped
        wr(16'h0100, 8'hE3, "R2 write");
        cfg_addr = 16'h0100; #0.05;
        check("R2 entry0 fields", 32'(cfg_rdata), 32'h83);
        // R3 high window last slot
        wr(16'h1128, 8'h8F, "R3 high");
        cfg_addr = 16'h1128; #0.05;
        check("R3 entry74", 32'(cfg_rdata), 32'h8F);
        cfg_addr = 16'h0101; #0.05;
        check("R3 misaligned read", 32'(cfg_rdata), 32'h0);
        cfg_addr = 16'h0200; #0.05;
        check("R3 gap read", 32'(cfg_rdata), 32'h0);
        wr(16'h1000, 8'h81, "R3 write outside");
        wr(16'h0102, 8'h81, "R3 misaligned write");
        readback("R3 after stray writes");

        // R6 / R7 on entry 0 -> channel 3
        req_i[0] = 1'b1; cycle("R6 rise entry0");
        check("R6 ch3 pulse", 32'(ras_set_o[3]), 32'h1);
        cycle("R6 held");
        check("R6 one cycle", 32'(ras_set_o[3]), 32'h0);
        req_i[0] = 1'b0; cycle("R7 fall entry0");
        check("R7 ch3 eor", 32'(eor_set_o[3]), 32'h1);
        // R5 unrouted line
        req_i[10] = 1'b1; cycle("R5 unrouted rise");
        check("R5 no level", 32'(ch_level_o), 32'h0);
        req_i[10] = 1'b0; cycle("R5 unrouted fall");
        // R8 set beats clr: entries 1 and 2 on channel 7
        wr(slot_addr(1), 8'h87, "R8 map1");
        wr(slot_addr(2), 8'h87, "R8 map2");
        req_i[1] = 1'b1; cycle("R8 prep");
        req_i[1] = 1'b0; req_i[2] = 1'b1; cycle("R8 same cycle");
        check("R8 clr suppressed", 32'(ras_clr_o[7]), 32'h0);
        check("R8 set high", 32'(ras_set_o[7]), 32'h1);
        req_i[2] = 1'b0; cycle("R8 drop");
        // R9 invalid entry with large number accepted, valid one refused
        wr(slot_addr(5), 8'h14, "R9 invalid large");
        check("R9 no err for invalid", 32'(cfg_err), 32'h0);
        wr(slot_addr(5), 8'h94, "R9 refused");
        cfg_addr = slot_addr(5); #0.05;
        check("R9 entry unchanged", 32'(cfg_rdata), 32'h14);
        check("R9 err set", 32'(cfg_err), 32'h1);
        cycle("R9 sticky");

        // random phase
        for (int n = 0; n < 600; n++) begin
            for (int i = 0; i < NREQ; i++)
                if ($urandom % 6 == 0) req_i[i] = ~req_i[i];
            if ($urandom % 3 == 0) begin
                cfg_we = 1'b1;
                cfg_addr = slot_addr($urandom % NREQ);
                cfg_wdata = 8'(($urandom % 2) << 7) | 8'($urandom % 20);
            end
            cycle("random");
        end
        readback("final");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule